// File: doc/BRIEF.md
# Instruction Cycle-Accounting Counter

This block keeps performance statistics for a processor core. The pipeline presents each retired instruction as a one-cycle pulse with an encoded instruction class. The block keeps a running count of retired instructions. It also keeps a running cycle total, which is built from one base cycle per instruction plus a fixed extra cost per class.

Two retirement lanes are provided. The primary lane carries any instruction. For a branch or return, it also carries a taken flag and a flag that says whether the branch has a delay slot. The secondary lane carries the instruction that executes in a delay slot, so it can retire in the same cycle as its branch. Both lanes are summed in one update. A synchronous clear zeroes both totals. A reported-cycles output gives the cycle total plus a fixed offset of two, and it reads zero while the total is zero.

Top module: `cyc_acct_top`

## Requirements
- R1: Each valid retirement on either lane adds one to the instruction count and one base cycle to the cycle count. Class 0 (plain ALU) adds nothing further, and both counters update on the clock edge that samples the pulse.
- R2: Class 1 (load) and class 2 (store) each add one extra cycle, for a total of 2 per instruction.
- R3: Class 3 (multiply), class 4 (barrel shift) and class 5 (custom accelerator) each add one extra cycle, for a total of 2.
- R4: Class 6 (divide) adds 33 extra cycles, for a total of 34.
- R5: Class 7 (branch or return) on the primary lane costs the following: 1 cycle when not taken, 2 cycles when taken with a delay slot, and 3 cycles when taken without one.
- R6: A delay-slot instruction on the secondary lane is charged with its own class cost. If that instruction is class 7, it gets no branch penalty. When both lanes are valid in one cycle, their instruction and cycle contributions are summed.
- R7: The reported cycle output equals the cycle count plus 2 while the count is nonzero, and equals 0 while the count is zero.
- R8: A clear zeroes both counters on the next edge. A retirement presented in the same cycle as a clear is discarded.
- R9: After reset, both counters and the reported output are 0.
- R10: When neither lane is valid, the class and flag inputs have no effect and both counters hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of both counters |
| vld0_i | input | 1 | Primary lane retirement pulse |
| cls0_i | input | 3 | Primary lane instruction class |
| taken0_i | input | 1 | Primary lane branch taken |
| dslot0_i | input | 1 | Primary lane branch has a delay slot |
| vld1_i | input | 1 | Delay-slot lane retirement pulse |
| cls1_i | input | 3 | Delay-slot lane instruction class |
| inst_cnt_o | output | 32 | Retired instruction count |
| cyc_cnt_o | output | 32 | Total cycle count |
| cyc_rpt_o | output | 32 | Reported cycles (count plus 2, or 0) |

## Verification
Every class is retired alone on the primary lane, so each per-class cost shows up as a distinct cycle increment. This separates the one-cycle, two-cycle and 34-cycle classes. Branches are tried in three forms: not taken, taken with a delay slot, and taken without one. Those three forms separate the two branch penalties, and pairing a branch with a delay-slot retirement on the second lane shows that the lanes are summed and that the second lane gets no branch penalty. Idle cycles with changing class inputs, a clear that coincides with a retirement, and the reported output read at zero and at a nonzero count cover the hold, clear-priority and offset rules.

// File: rtl/cyc_acct_pkg.sv
package cyc_acct_pkg;
  localparam int unsigned CLS_W = 3;

  typedef enum logic [CLS_W-1:0] {
    CLS_ALU    = 3'd0,
    CLS_LOAD   = 3'd1,
    CLS_STORE  = 3'd2,
    CLS_MUL    = 3'd3,
    CLS_BSHIFT = 3'd4,
    CLS_ACCEL  = 3'd5,
    CLS_DIV    = 3'd6,
    CLS_BRANCH = 3'd7
  } instr_cls_e;

  localparam int unsigned BASE_COST  = 1;
  localparam int unsigned MEM_PEN    = 1;
  localparam int unsigned ARITH_PEN  = 1;
  localparam int unsigned DIV_PEN    = 33;
  localparam int unsigned TAKEN_PEN  = 1;
  localparam int unsigned NODS_PEN   = 1;
  localparam int unsigned MAX_COST   = BASE_COST + DIV_PEN + TAKEN_PEN + NODS_PEN;
  localparam int unsigned COST_W     = $clog2(MAX_COST + 1);
endpackage

// File: rtl/cyc_acct_cost.sv
module cyc_acct_cost
  import cyc_acct_pkg::*;
#(
  parameter bit BRANCH_EN = 1'b1
) (
  input  logic              vld_i,
  input  logic [CLS_W-1:0]  cls_i,
  input  logic              taken_i,
  input  logic              dslot_i,
  output logic [COST_W-1:0] cost_o
);
  logic [COST_W-1:0] class_cost;
  logic [COST_W-1:0] br_cost;

  always_comb begin
    unique case (instr_cls_e'(cls_i))
      CLS_LOAD, CLS_STORE:            class_cost = COST_W'(BASE_COST + MEM_PEN);
      CLS_MUL, CLS_BSHIFT, CLS_ACCEL: class_cost = COST_W'(BASE_COST + ARITH_PEN);
      CLS_DIV:                        class_cost = COST_W'(BASE_COST + DIV_PEN);
      default:                        class_cost = COST_W'(BASE_COST);
    endcase
  end

  generate
    if (BRANCH_EN) begin : g_branch
      always_comb begin
        br_cost = '0;
        if (instr_cls_e'(cls_i) == CLS_BRANCH && taken_i) begin
          br_cost = COST_W'(TAKEN_PEN);
          if (!dslot_i) br_cost = COST_W'(TAKEN_PEN + NODS_PEN);
        end
      end
    end else begin : g_no_branch
      logic unused_flags;
      assign unused_flags = taken_i ^ dslot_i;
      assign br_cost = '0;
    end
  endgenerate

  assign cost_o = vld_i ? (class_cost + br_cost) : '0;
endmodule

// File: rtl/cyc_acct_cnt.sv
module cyc_acct_cnt #(
  parameter int unsigned W     = 32,
  parameter int unsigned INC_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [INC_W-1:0] inc_i,
  output logic [W-1:0]     cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else            cnt_o <= cnt_o + W'(inc_i);
  end

  // R8
  a_r8_clr_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_o == '0);
endmodule

// File: rtl/cyc_acct_top.sv
module cyc_acct_top
  import cyc_acct_pkg::*;
#(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned RPT_OFS = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             vld0_i,
  input  logic [2:0]       cls0_i,
  input  logic             taken0_i,
  input  logic             dslot0_i,
  input  logic             vld1_i,
  input  logic [2:0]       cls1_i,
  output logic [CNT_W-1:0] inst_cnt_o,
  output logic [CNT_W-1:0] cyc_cnt_o,
  output logic [CNT_W-1:0] cyc_rpt_o
);
  localparam int unsigned LANES  = 2;
  localparam int unsigned SUM_W  = COST_W + 1;
  localparam int unsigned NINC_W = $clog2(LANES + 1);

  logic [LANES-1:0]              lane_vld;
  logic [LANES-1:0][CLS_W-1:0]   lane_cls;
  logic [LANES-1:0]              lane_tkn;
  logic [LANES-1:0]              lane_ds;
  logic [LANES-1:0][COST_W-1:0]  lane_cost;
  logic [SUM_W-1:0]              cyc_inc;
  logic [NINC_W-1:0]             inst_inc;

  assign lane_vld = {vld1_i, vld0_i};
  assign lane_cls = {cls1_i, cls0_i};
  assign lane_tkn = {1'b0, taken0_i};
  assign lane_ds  = {1'b0, dslot0_i};

  // only the primary lane may carry a branch penalty
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    cyc_acct_cost #(.BRANCH_EN(l == 0)) i_cost (
      .vld_i   (lane_vld[l]),
      .cls_i   (lane_cls[l]),
      .taken_i (lane_tkn[l]),
      .dslot_i (lane_ds[l]),
      .cost_o  (lane_cost[l])
    );
  end

  always_comb begin
    cyc_inc  = '0;
    inst_inc = '0;
    for (int l = 0; l < LANES; l++) begin
      cyc_inc  = cyc_inc + SUM_W'(lane_cost[l]);
      inst_inc = inst_inc + NINC_W'(lane_vld[l]);
    end
  end

  cyc_acct_cnt #(.W(CNT_W), .INC_W(NINC_W)) i_inst_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .inc_i  (inst_inc),
    .cnt_o  (inst_cnt_o)
  );

  cyc_acct_cnt #(.W(CNT_W), .INC_W(SUM_W)) i_cyc_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .inc_i  (cyc_inc),
    .cnt_o  (cyc_cnt_o)
  );

  assign cyc_rpt_o = (cyc_cnt_o != '0) ? cyc_cnt_o + CNT_W'(RPT_OFS) : '0;

  // R1
  a_r1_inst_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && (vld0_i || vld1_i)) |=>
      inst_cnt_o == $past(inst_cnt_o) + CNT_W'($past(vld0_i)) + CNT_W'($past(vld1_i)));

  // R4
  a_r4_div_cost: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && vld0_i && cls0_i == CLS_DIV && !vld1_i) |=>
      cyc_cnt_o == $past(cyc_cnt_o) + CNT_W'(34));

  // R10
  a_r10_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !vld0_i && !vld1_i) |=> $stable(inst_cnt_o) && $stable(cyc_cnt_o));

  // R7
  a_r7_rpt_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_cnt_o == '0) |-> (cyc_rpt_o == '0));
endmodule

// File: tb/test_cyc_acct_top.sv
module test_cyc_acct_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clr_i = 1'b0;
  logic        vld0_i = 1'b0;
  logic [2:0]  cls0_i = '0;
  logic        taken0_i = 1'b0;
  logic        dslot0_i = 1'b0;
  logic        vld1_i = 1'b0;
  logic [2:0]  cls1_i = '0;
  logic [31:0] inst_cnt_o, cyc_cnt_o, cyc_rpt_o;

  int errors = 0;
  int checks = 0;
  logic [31:0] exp_inst = '0;
  logic [31:0] exp_cyc  = '0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  cyc_acct_top i_cyc_acct_top (
    .clk_i, .rst_ni, .clr_i, .vld0_i, .cls0_i, .taken0_i, .dslot0_i,
    .vld1_i, .cls1_i, .inst_cnt_o, .cyc_cnt_o, .cyc_rpt_o
  );

  function automatic int unsigned cost(input bit [2:0] c, input bit tk, input bit ds, input bit prim);
    int unsigned v;
    case (c)
      3'd1, 3'd2, 3'd3, 3'd4, 3'd5: v = 2;
      3'd6:                         v = 34;
      default:                      v = 1;
    endcase
    if (prim && c == 3'd7 && tk) v = ds ? 2 : 3;
    return v;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk(req, inst_cnt_o, exp_inst);
    chk(req, cyc_cnt_o, exp_cyc);
    chk("R7", cyc_rpt_o, (exp_cyc != 0) ? exp_cyc + 2 : 32'd0);
  endtask

  // drive at negedge, edge samples, check at following negedge
  task automatic retire(input bit v0, input bit [2:0] c0, input bit tk, input bit ds,
                        input bit v1, input bit [2:0] c1, input string req);
    vld0_i = v0; cls0_i = c0; taken0_i = tk; dslot0_i = ds;
    vld1_i = v1; cls1_i = c1;
    @(posedge clk_i);
    if (v0) begin exp_inst += 1; exp_cyc += cost(c0, tk, ds, 1'b1); end
    if (v1) begin exp_inst += 1; exp_cyc += cost(c1, 1'b0, 1'b0, 1'b0); end
    @(negedge clk_i);
    vld0_i = 0; vld1_i = 0; taken0_i = 0; dslot0_i = 0;
    chk_all(req);
  endtask

  task automatic do_clear(input bit with_ret);
    clr_i = 1; vld0_i = with_ret; cls0_i = 3'd6;
    @(posedge clk_i);
    exp_inst = 0; exp_cyc = 0;
    @(negedge clk_i);
    clr_i = 0; vld0_i = 0;
    chk_all("R8");
  endtask

  task automatic t_reset();
    chk_all("R9");
  endtask

  task automatic t_alu();
    retire(1, 3'd0, 0, 0, 0, 3'd0, "R1");
    retire(1, 3'd0, 0, 0, 0, 3'd0, "R1");
  endtask

  task automatic t_mem();
    retire(1, 3'd1, 0, 0, 0, 3'd0, "R2");
    retire(1, 3'd2, 0, 0, 0, 3'd0, "R2");
  endtask

  task automatic t_arith();
    for (int c = 3; c <= 5; c++) retire(1, 3'(c), 0, 0, 0, 3'd0, "R3");
  endtask

  task automatic t_div();
    retire(1, 3'd6, 0, 0, 0, 3'd0, "R4");
  endtask

  task automatic t_branch();
    retire(1, 3'd7, 0, 0, 0, 3'd0, "R5");
    retire(1, 3'd7, 1, 1, 0, 3'd0, "R5");
    retire(1, 3'd7, 1, 0, 0, 3'd0, "R5");
  endtask

  task automatic t_dual();
    retire(1, 3'd7, 1, 1, 1, 3'd6, "R6");
    retire(1, 3'd1, 0, 0, 1, 3'd7, "R6");
    retire(1, 3'd3, 0, 0, 1, 3'd2, "R6");
  endtask

  task automatic t_idle();
    cls0_i = 3'd6; taken0_i = 1; cls1_i = 3'd6;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    taken0_i = 0;
    chk_all("R10");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_alu();
    t_mem();
    t_arith();
    t_div();
    t_branch();
    t_dual();
    t_idle();
    do_clear(1'b1);
    t_div();
    do_clear(1'b0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule